// File: doc/BRIEF.md
# Touch Key Rollover Limiter

This block sits between a bank of per-key raw touch flags and the active-high key outputs of a touch keypad controller. It limits how many keys are reported at the same moment. Keys keep the order in which they became touched, and the earliest ones get the reporting slots. Sensing, filtering and calibration happen upstream. This block only decides which of the currently touched keys are shown.

A mode input selects the cap. When it is high, two keys can be reported together. When it is low, only one key is reported. A key that is touched but held back waits its turn. When a reported key is released, the oldest waiting key takes its slot. If several keys become touched in the same clock cycle, lower key indices come first in the order. The outputs are registered, so each output follows the raw flags sampled one clock earlier.

Top module: `key_rollover_limiter`

## Requirements
- R1: `key_out[i]` is high only if `raw_touch[i]` was high at the preceding rising clock edge. Outputs are registered, with one cycle of latency.
- R2: The number of high outputs never exceeds the cap. The cap is MAX_SLOTS (default 2) when `two_key_mode` is 1 and 1 when it is 0. The cap uses the mode value sampled at the same edge as the raw flags.
- R3: When the number of touched keys is at or below the cap, every touched key is reported one cycle later.
- R4: When more keys are touched than the cap allows, the keys that became touched earliest are reported. A key that is reported and still held is never displaced by a later key while the mode is unchanged.
- R5: When a reported key is released, the longest-waiting key that is still touched is reported from the next cycle. Waiting keys are promoted in the order they became touched.
- R6: Keys that become touched in the same clock cycle are ordered by index, lowest first, for the free slots.
- R7: With `two_key_mode` at 0, exactly the earliest touched key is reported while any key is touched.
- R8: While `rst_n` is low, all outputs are low and the arrival order is cleared. Keys held at reset release count as arriving together at the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_touch | input | NUM_KEYS | Per-key raw touch flags, 1 = touched |
| two_key_mode | input | 1 | 1: cap is MAX_SLOTS keys; 0: cap is one key |
| key_out | output | NUM_KEYS | Registered active-high key reports |

## Verification
The bench targets the following cases, each paired with the faulty behaviour it would expose:

- A third key arriving while two are held. A design with a fixed index priority would let a low-numbered late key steal a slot.
- Release of a reported key while two others wait. A design that promotes by index instead of by age would pick the wrong one.
- Several keys arriving in one cycle with fewer slots than keys. This checks the tie-break toward the lower index.
- Switching to one-key mode with keys held. A design that ignores the mode would show two keys.
- Reset while keys are held. A design that failed to clear its order would report stale keys afterwards.

A long random stretch compares every cycle against a behavioural queue model.

// File: rtl/key_rollover_pkg.sv
package key_rollover_pkg;

    typedef enum logic {
        CAP_SINGLE = 1'b0,
        CAP_MULTI  = 1'b1
    } cap_mode_e;

    // Number of reporting slots for a given mode setting.
    function automatic int slot_cap(input logic multi_mode, input int max_slots);
        return (cap_mode_e'(multi_mode) == CAP_MULTI) ? max_slots : 1;
    endfunction

endpackage

// File: rtl/rollover_arrival_queue.sv
module rollover_arrival_queue #(
    parameter int NUM_KEYS = 4,
    parameter int IDX_W    = 2,
    parameter int CNT_W    = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_KEYS-1:0]                raw_touch,
    output logic [NUM_KEYS-1:0][IDX_W-1:0]     order_d,
    output logic [CNT_W-1:0]                   depth_d
);

    // order[0] is the oldest touched key; depth counts valid entries.
    typedef struct packed {
        logic [NUM_KEYS-1:0][IDX_W-1:0] order;
        logic [CNT_W-1:0]               depth;
        logic [NUM_KEYS-1:0]            held;
    } queue_t;

    queue_t st_q, st_d;

    always_comb begin
        int fill;
        st_d = '0;
        fill = 0;
        // Keep surviving entries in their existing order.
        for (int i = 0; i < NUM_KEYS; i++) begin
            if (i < int'(st_q.depth)) begin
                if (raw_touch[st_q.order[i]]) begin
                    st_d.order[fill] = st_q.order[i];
                    fill++;
                end
            end
        end
        // Append fresh arrivals, lowest index first.
        for (int k = 0; k < NUM_KEYS; k++) begin
            if (raw_touch[k] && !st_q.held[k]) begin
                st_d.order[fill] = IDX_W'(k);
                fill++;
            end
        end
        st_d.depth = CNT_W'(fill);
        st_d.held  = raw_touch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign order_d = st_d.order;
    assign depth_d = st_d.depth;

    AST_DEPTH_MATCHES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.depth) == $countones(st_q.held)); // R5

endmodule

// File: rtl/rollover_slot_grant.sv
module rollover_slot_grant
    import key_rollover_pkg::*;
#(
    parameter int NUM_KEYS  = 4,
    parameter int IDX_W     = 2,
    parameter int CNT_W     = 3,
    parameter int MAX_SLOTS = 2
) (
    input  logic [NUM_KEYS-1:0][IDX_W-1:0] order,
    input  logic [CNT_W-1:0]               depth,
    input  logic                           multi_mode,
    output logic [NUM_KEYS-1:0]            grant
);

    always_comb begin
        int cap;
        grant = '0;
        cap   = slot_cap(multi_mode, MAX_SLOTS);
        for (int s = 0; s < NUM_KEYS; s++) begin
            if (s < cap && s < int'(depth)) begin
                grant[order[s]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/key_rollover_limiter.sv
module key_rollover_limiter
    import key_rollover_pkg::*;
#(
    parameter int NUM_KEYS  = 4,
    parameter int MAX_SLOTS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] raw_touch,
    input  logic                two_key_mode,
    output logic [NUM_KEYS-1:0] key_out
);

    localparam int IDX_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1;
    localparam int CNT_W = $clog2(NUM_KEYS + 1);

    typedef struct packed {
        logic [NUM_KEYS-1:0] outs;
    } out_t;

    out_t st_q, st_d;

    logic [NUM_KEYS-1:0][IDX_W-1:0] order_d;
    logic [CNT_W-1:0]               depth_d;
    logic [NUM_KEYS-1:0]            grant_d;

    rollover_arrival_queue #(
        .NUM_KEYS (NUM_KEYS),
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_touch (raw_touch),
        .order_d   (order_d),
        .depth_d   (depth_d)
    );

    rollover_slot_grant #(
        .NUM_KEYS  (NUM_KEYS),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W),
        .MAX_SLOTS (MAX_SLOTS)
    ) u_grant (
        .order      (order_d),
        .depth      (depth_d),
        .multi_mode (two_key_mode),
        .grant      (grant_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.outs = grant_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign key_out = st_q.outs;

    // Cycles since reset, so that $past never reaches into reset.
    logic [1:0] armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 2'b00;
        end else begin
            armed_q <= {armed_q[0], 1'b1};
        end
    end

    AST_OUT_NEEDS_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q[0] |-> ((key_out & ~$past(raw_touch)) == '0)); // R1

    AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q[0] |-> ($countones(key_out) <= slot_cap($past(two_key_mode), MAX_SLOTS))); // R2

    AST_ALL_FIT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q[0] && $countones($past(raw_touch)) <= slot_cap($past(two_key_mode), MAX_SLOTS))
        |-> (key_out == $past(raw_touch))); // R3

    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q[1] && $past(two_key_mode) == $past(two_key_mode, 2))
        |-> (($past(key_out) & $past(raw_touch) & ~key_out) == '0)); // R4

endmodule

// File: tb/key_rollover_limiter_bench.sv
`timescale 1ns/1ps
module key_rollover_limiter_bench;

    localparam int NK = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NK-1:0] raw_touch = '0;
    logic          two_key_mode = 1'b1;
    logic [NK-1:0] key_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int            model_q[$];
    logic [NK-1:0] model_prev = '0;
    logic [NK-1:0] model_exp  = '0;

    always #2 clk = ~clk;

    key_rollover_limiter u_key_rollover_limiter (
        .clk          (clk),
        .rst_n        (rst_n),
        .raw_touch    (raw_touch),
        .two_key_mode (two_key_mode),
        .key_out      (key_out)
    );

    // Behavioural reference: an age-ordered list of touched keys.
    task automatic model_edge(input logic [NK-1:0] r, input logic m);
        int nq[$];
        int cap;
        foreach (model_q[j]) if (r[model_q[j]]) nq.push_back(model_q[j]);
        for (int k = 0; k < NK; k++) if (r[k] && !model_prev[k]) nq.push_back(k);
        model_q    = nq;
        model_prev = r;
        cap        = m ? 2 : 1;
        model_exp  = '0;
        for (int j = 0; j < nq.size() && j < cap; j++) model_exp[nq[j]] = 1'b1;
    endtask

    task automatic check(input string tag, input logic [NK-1:0] expv);
        n_tests++;
        if (key_out !== expv) begin
            n_fail++;
            $display("FAIL %s: key_out=%b expected=%b", tag, key_out, expv);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input logic [NK-1:0] r, input logic m, input string tag);
        raw_touch    = r;
        two_key_mode = m;
        @(posedge clk);
        model_edge(r, m);
        #1;
        check(tag, model_exp);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset low", 4'b0000);
        rst_n = 1'b1;

        step(4'b0001, 1, "R1 single key");
        step(4'b0011, 1, "R3 two keys fit");
        step(4'b0111, 1, "R4 third key held back");
        step(4'b0111, 1, "R4 no preemption");
        step(4'b0110, 1, "R5 promote waiting key");
        step(4'b1110, 1, "R4 late key waits");
        step(4'b1100, 1, "R5 promote by age");
        if (key_out !== 4'b1100) begin n_fail++; n_tests++;
            $display("FAIL R5 literal: key_out=%b expected=%b", key_out, 4'b1100); end
        else n_tests++;
        step(4'b0000, 1, "R1 all released");
        step(4'b1110, 1, "R6 same-cycle tie");
        if (key_out !== 4'b0110) begin n_fail++; n_tests++;
            $display("FAIL R6 literal: key_out=%b expected=%b", key_out, 4'b0110); end
        else n_tests++;
        step(4'b1010, 1, "R5 tie loser promoted");
        step(4'b0000, 0, "R7 idle single mode");
        step(4'b1000, 0, "R7 one key");
        step(4'b1001, 0, "R7 earliest kept");
        step(4'b0001, 0, "R7 handover");
        step(4'b0111, 0, "R2 single cap");
        step(4'b0111, 1, "R2 back to two");

        // Reset with keys held: order is rebuilt from scratch.
        raw_touch = 4'b0101;
        rst_n     = 1'b0;
        model_q.delete();
        model_prev = '0;
        @(negedge clk);
        check("R8 reset while held", 4'b0000);
        rst_n = 1'b1;
        step(4'b0101, 1, "R8 held keys after reset");
        step(4'b1101, 1, "R4 after reset");

        for (int c = 0; c < 3000; c++) begin
            logic [NK-1:0] r;
            logic m;
            r = NK'($urandom_range(0, 15));
            m = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 3) != 0) r = (raw_touch & NK'($urandom_range(0, 15))) | (r & NK'($urandom_range(0, 15)));
            step(r, m, "R2 random");
        end

        finish_run();
    end

endmodule